// File: doc/BRIEF.md
# SDRAM Auto-Refresh Scheduler

This block keeps a DDR SDRAM supplied with refresh commands while the main memory controller carries on with normal traffic. A free-running interval counter expires once per average refresh period, 1560 clocks at a 5 ns clock or 7.8 us. Each expiry adds one refresh to a count of refreshes owed. The block asks an arbiter for the command bus. Once it is granted, it asks for every bank to be closed and waits until all banks report idle. It then issues one auto-refresh and blocks further commands for the refresh row cycle time. While the arbiter is busy, refreshes can be postponed, up to a limit of eight. When the limit is reached, the block raises an urgent flag.

The same handshake also puts the device into self-refresh. The refresh command is issued with the clock enable driven low, and the clock enable stays low for as long as self-refresh is requested. When the request is withdrawn, the clock enable rises. Two separate holds are then kept: a short one against any non-read command, and a long one against reads.

Top module: `refresh_sched`

## Requirements
- R1: A synchronous active-low reset leaves `owedCount` at 0, `refReq`, `refUrgent`, `refCmd`, `holdCmd` and `holdRead` low, and `cke` high.
- R2: While not in self-refresh or its exit window, `owedCount` grows by one every `INTERVAL` clocks. The first increment comes `INTERVAL` rising edges after reset is released.
- R3: `owedCount` never exceeds `MAX_OWED`. An expiry that happens while the count is already full is dropped.
- R4: In the idle state, `refReq` is high exactly when `owedCount` is nonzero or `selfReq` is high. `refUrgent` is high exactly when `owedCount` equals `MAX_OWED`.
- R5: Once `refGrant` is sampled high with `refReq` high, `holdCmd` is high from the next cycle. `prechargeReq` is high while `banksIdle` is low. `refCmd` is only ever high in a cycle where `banksIdle` is high.
- R6: Each auto-refresh command (`refCmd` high with `cke` high) lowers `owedCount` by one. An interval expiry on the same edge cancels the decrement.
- R7: After an auto-refresh command, `holdCmd` stays high for the next `TRFC-1` cycles and then falls. No refresh command appears in that window.
- R8: Self-refresh entry is a `refCmd` cycle with `cke` low. `cke` then stays low while `selfReq` stays high. During self-refresh, `owedCount` does not change and the interval counter is held.
- R9: When `selfReq` is low during self-refresh, `cke` rises in the next cycle. `holdCmd` is then high for exactly `TXSNR` cycles and `holdRead` for exactly `TXSRD` cycles, both counted from the cycle in which `cke` rises.
- R10: `refGrant` has no effect while `refReq` is low: `holdCmd` stays low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| refGrant | input | 1 | Arbiter grants the command bus for a refresh |
| banksIdle | input | 1 | All banks are precharged |
| selfReq | input | 1 | Level request to enter and stay in self-refresh |
| refReq | output | 1 | Refresh or self-refresh wanted |
| refUrgent | output | 1 | Owed count at its cap |
| prechargeReq | output | 1 | Close all open rows now |
| refCmd | output | 1 | Drive the refresh command encoding this cycle |
| cke | output | 1 | Clock enable toward the device |
| holdCmd | output | 1 | Only NOP or deselect may be issued |
| holdRead | output | 1 | No read may be issued |
| owedCount | output | clog2(MAX_OWED+1) | Refreshes currently owed |

## Verification
The bench builds the block with `INTERVAL`=40, `TRFC`=4, `TXSNR`=5 and `TXSRD`=12, and keeps `MAX_OWED` at 8. The short interval lets the owed count reach its cap, and then overflow, within a few hundred cycles. The short windows let the bench count every cycle of the refresh hold and of both exit holds exactly. A random run then mixes grants with delayed bank-idle reports, so that interval expiries coincide with issued refreshes.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_RFC,
    ST_SELF,
    ST_EXIT
  } schedState_t;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic tickEn;   // interval counter runs
    logic consume;  // one refresh paid off
    logic waitClr;  // restart the window counter
  } dpStrobe_t;

endpackage

// File: rtl/refsched_dp.sv
module refsched_dp
  import refsched_pkg::*;
#(
  parameter int INTERVAL = 1560,
  parameter int MAX_OWED = 8,
  parameter int OWED_W   = 4,
  parameter int WAIT_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  output logic [OWED_W-1:0] owedCount,
  output logic [WAIT_W-1:0] waitCnt
);

  localparam int IVL_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [IVL_W-1:0]  IVL_RELOAD = IVL_W'(INTERVAL - 1);
  localparam logic [OWED_W-1:0] OWED_CAP   = OWED_W'(MAX_OWED);
  localparam logic [WAIT_W-1:0] WAIT_TOP   = '1;

  logic [IVL_W-1:0] ivlCnt;
  logic             expire;

  assign expire = strobe.tickEn && (ivlCnt == '0);

  // Interval counter: reloads whenever it is held or expires.
  always_ff @(posedge clk) begin
    if (!rstN || !strobe.tickEn || expire) ivlCnt <= IVL_RELOAD;
    else                                   ivlCnt <= ivlCnt - 1'b1;
  end

  // Owed refreshes, saturating at the cap.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      owedCount <= '0;
    end else if (expire && !strobe.consume) begin
      if (owedCount != OWED_CAP) owedCount <= owedCount + 1'b1;
    end else if (strobe.consume && !expire) begin
      if (owedCount != '0) owedCount <= owedCount - 1'b1;
    end
  end

  // Shared window counter for the refresh hold and the exit holds.
  always_ff @(posedge clk) begin
    if (!rstN || strobe.waitClr) waitCnt <= '0;
    else if (waitCnt != WAIT_TOP) waitCnt <= waitCnt + 1'b1;
  end

endmodule

// File: rtl/refsched_ctl.sv
module refsched_ctl
  import refsched_pkg::*;
#(
  parameter int MAX_OWED = 8,
  parameter int TRFC     = 14,
  parameter int TXSNR    = 15,
  parameter int TXSRD    = 200,
  parameter int OWED_W   = 4,
  parameter int WAIT_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refGrant,
  input  logic              banksIdle,
  input  logic              selfReq,
  input  logic [OWED_W-1:0] owedCount,
  input  logic [WAIT_W-1:0] waitCnt,
  output dpStrobe_t         strobe,
  output logic              refReq,
  output logic              refUrgent,
  output logic              prechargeReq,
  output logic              refCmd,
  output logic              cke,
  output logic              holdCmd,
  output logic              holdRead
);

  localparam logic [WAIT_W-1:0] RFC_LAST  = WAIT_W'(TRFC - 2);
  localparam logic [WAIT_W-1:0] SNR_LEN   = WAIT_W'(TXSNR);
  localparam logic [WAIT_W-1:0] SRD_LEN   = WAIT_W'(TXSRD);
  localparam logic [WAIT_W-1:0] EXIT_LAST = WAIT_W'(TXSRD - 1);
  localparam logic [OWED_W-1:0] OWED_CAP  = OWED_W'(MAX_OWED);

  schedState_t state, stateNxt;
  logic        doSelf;
  logic        wantRef;
  logic        issue;

  assign wantRef = (owedCount != '0) || selfReq;
  assign issue   = (state == ST_ARM) && banksIdle;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE: if (refGrant && wantRef) stateNxt = ST_ARM;
      ST_ARM:  if (banksIdle) stateNxt = doSelf ? ST_SELF : ST_RFC;
      ST_RFC:  if (waitCnt == RFC_LAST) stateNxt = ST_IDLE;
      ST_SELF: if (!selfReq) stateNxt = ST_EXIT;
      ST_EXIT: if (waitCnt == EXIT_LAST) stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      doSelf <= 1'b0;
    end else begin
      state <= stateNxt;
      if (state == ST_IDLE && refGrant && wantRef) doSelf <= selfReq;
    end
  end

  always_comb begin
    strobe.tickEn  = (state != ST_SELF) && (state != ST_EXIT);
    strobe.consume = issue && !doSelf;
    strobe.waitClr = issue || (state == ST_SELF);
  end

  assign refReq       = (state == ST_IDLE) && wantRef;
  assign refUrgent    = (owedCount == OWED_CAP);
  assign prechargeReq = (state == ST_ARM) && !banksIdle;
  assign refCmd       = issue;
  assign cke          = !((state == ST_SELF) || (issue && doSelf));
  assign holdCmd      = (state == ST_ARM) || (state == ST_RFC) || (state == ST_SELF) ||
                        ((state == ST_EXIT) && (waitCnt < SNR_LEN));
  assign holdRead     = holdCmd || ((state == ST_EXIT) && (waitCnt < SRD_LEN));

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refsched_pkg::*;
#(
  parameter int INTERVAL = 1560,
  parameter int MAX_OWED = 8,
  parameter int TRFC     = 14,
  parameter int TXSNR    = 15,
  parameter int TXSRD    = 200
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          refGrant,
  input  logic                          banksIdle,
  input  logic                          selfReq,
  output logic                          refReq,
  output logic                          refUrgent,
  output logic                          prechargeReq,
  output logic                          refCmd,
  output logic                          cke,
  output logic                          holdCmd,
  output logic                          holdRead,
  output logic [$clog2(MAX_OWED+1)-1:0] owedCount
);

  localparam int OWED_W  = $clog2(MAX_OWED + 1);
  localparam int WIN_MAX = (TXSRD > TRFC) ? TXSRD : TRFC;
  localparam int WAIT_W  = $clog2(WIN_MAX + 1) + 1;

  dpStrobe_t         strobe;
  logic [WAIT_W-1:0] waitCnt;

  refsched_dp #(
    .INTERVAL(INTERVAL), .MAX_OWED(MAX_OWED), .OWED_W(OWED_W), .WAIT_W(WAIT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .owedCount(owedCount), .waitCnt(waitCnt)
  );

  refsched_ctl #(
    .MAX_OWED(MAX_OWED), .TRFC(TRFC), .TXSNR(TXSNR), .TXSRD(TXSRD),
    .OWED_W(OWED_W), .WAIT_W(WAIT_W)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .refGrant(refGrant), .banksIdle(banksIdle),
    .selfReq(selfReq), .owedCount(owedCount), .waitCnt(waitCnt),
    .strobe(strobe), .refReq(refReq), .refUrgent(refUrgent),
    .prechargeReq(prechargeReq), .refCmd(refCmd), .cke(cke),
    .holdCmd(holdCmd), .holdRead(holdRead)
  );

endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int MAX_OWED = 8,
  parameter int OWED_W   = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              refGrant,
  input logic              refUrgent,
  input logic              refCmd,
  input logic              cke,
  input logic              holdCmd,
  input logic              holdRead,
  input logic [OWED_W-1:0] owedCount
);

  p_owed_cap_r3: assert property (@(posedge clk) disable iff (!rstN)
    int'(owedCount) <= MAX_OWED);

  p_owed_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    int'(owedCount) <= int'($past(owedCount)) + 1);

  p_urgent_keep_r4: assert property (@(posedge clk) disable iff (!rstN)
    (refUrgent && !(refCmd && cke)) |=> refUrgent);

  p_cmd_after_grant_r5: assert property (@(posedge clk) disable iff (!rstN)
    refCmd |-> ($past(refGrant) || $past(holdCmd)));

  p_rfc_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (refCmd && cke) |=> (holdCmd && !refCmd));

  p_self_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!cke && !refCmd) |-> (holdCmd && holdRead));

  p_exit_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cke) |-> (holdCmd && holdRead));

endmodule

bind refresh_sched refresh_sched_chk #(
  .MAX_OWED(MAX_OWED), .OWED_W($clog2(MAX_OWED + 1))
) u_chk (
  .clk(clk), .rstN(rstN), .refGrant(refGrant), .refUrgent(refUrgent),
  .refCmd(refCmd), .cke(cke), .holdCmd(holdCmd), .holdRead(holdRead),
  .owedCount(owedCount)
);

// File: tb/refresh_sched_tb.sv
`timescale 1ns/1ps
module refresh_sched_tb;

  localparam int INTERVAL = 40;
  localparam int MAX_OWED = 8;
  localparam int TRFC     = 4;
  localparam int TXSNR    = 5;
  localparam int TXSRD    = 12;
  localparam int OW       = $clog2(MAX_OWED + 1);

  logic clk = 1'b0;
  logic rstN, refGrant, banksIdle, selfReq;
  logic refReq, refUrgent, prechargeReq, refCmd, cke, holdCmd, holdRead;
  logic [OW-1:0] owedCount;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  // bench model state
  int expOwed, phase, exitLeft, rfcLeft;

  always #4 clk = ~clk;

  refresh_sched #(
    .INTERVAL(INTERVAL), .MAX_OWED(MAX_OWED), .TRFC(TRFC),
    .TXSNR(TXSNR), .TXSRD(TXSRD)
  ) u_dut (
    .clk(clk), .rstN(rstN), .refGrant(refGrant), .banksIdle(banksIdle),
    .selfReq(selfReq), .refReq(refReq), .refUrgent(refUrgent),
    .prechargeReq(prechargeReq), .refCmd(refCmd), .cke(cke),
    .holdCmd(holdCmd), .holdRead(holdRead), .owedCount(owedCount)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int nextOwed(input int cur, input bit tk, input bit paid);
    if (tk && !paid) return (cur < MAX_OWED) ? cur + 1 : cur;
    if (paid && !tk) return (cur > 0) ? cur - 1 : cur;
    return cur;
  endfunction

  // One clock: sample this cycle, update the model at the edge, check after it.
  task automatic step();
    bit oRef, oCke, oHold, oIdle, oSelf, frozen, tk, paid;
    #1;
    oRef = refCmd; oCke = cke; oHold = holdCmd; oIdle = banksIdle; oSelf = selfReq;
    if (oRef) check(oIdle, "R5 refresh only with banks idle", int'(oIdle), 1);
    if (rfcLeft > 0) begin
      check(oHold && !oRef, "R7 hold after refresh", int'(oHold), 1);
      rfcLeft--;
    end
    frozen = 1'b0;
    if (exitLeft > 0) begin
      frozen = 1'b1;
      exitLeft--;
    end else if (!oCke && !oRef) begin
      frozen = 1'b1;
      if (!oSelf) exitLeft = TXSRD;
    end
    paid = oRef && oCke;
    if (paid) rfcLeft = TRFC - 1;
    tk = 1'b0;
    if (frozen) phase = 0;
    else begin
      phase++;
      if (phase == INTERVAL) begin tk = 1'b1; phase = 0; end
    end
    @(posedge clk);
    expOwed = nextOwed(expOwed, tk, paid);
    @(negedge clk);
    check(int'(owedCount) == expOwed, "R2 owed count tracks interval", int'(owedCount), expOwed);
  endtask

  task automatic doReset();
    rstN = 1'b0; refGrant = 1'b0; banksIdle = 1'b0; selfReq = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(owedCount == '0, "R1 owed after reset", int'(owedCount), 0);
    check(!refReq && !refUrgent && !refCmd, "R1 requests after reset",
          int'({refReq, refUrgent, refCmd}), 0);
    check(cke && !holdCmd && !holdRead, "R1 cke/holds after reset",
          int'({cke, holdCmd, holdRead}), 4);
    rstN = 1'b1;
    expOwed = 0; phase = 0; exitLeft = 0; rfcLeft = 0;
  endtask

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        nChecks++; nFails++;
        $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
        $finish;
      end
    end
  end

  initial begin
    int n, nh, nr, o;
    void'($urandom(32'd1234));
    doReset();

    // R10: grant with nothing owed is ignored
    repeat (3) step();
    refGrant = 1'b1;
    step();
    refGrant = 1'b0;
    #1;
    check(!holdCmd, "R10 grant ignored without request", int'(holdCmd), 0);

    // R2/R4: first expiry after INTERVAL edges
    while (phase != INTERVAL - 1) step();
    #1;
    check(owedCount == '0 && !refReq, "R4 no request before expiry", int'(refReq), 0);
    step();
    #1;
    check(owedCount == OW'(1), "R2 first expiry", int'(owedCount), 1);
    check(refReq, "R4 request with owed refresh", int'(refReq), 1);

    // R3/R4: accumulate to the cap, then overflow one more interval
    while (int'(owedCount) < MAX_OWED && cycles < 20000) step();
    #1;
    check(refUrgent, "R4 urgent at cap", int'(refUrgent), 1);
    repeat (INTERVAL + 2) step();
    check(int'(owedCount) == MAX_OWED, "R3 owed saturates", int'(owedCount), MAX_OWED);

    // R5: grant while banks still open
    refGrant = 1'b1; banksIdle = 1'b0;
    step();
    refGrant = 1'b0;
    for (int i = 0; i < 3; i++) begin
      #1;
      check(holdCmd && prechargeReq && !refCmd, "R5 precharge wait",
            int'({holdCmd, prechargeReq, refCmd}), 6);
      step();
    end
    banksIdle = 1'b1;
    #1;
    check(refCmd && cke, "R5 refresh once banks idle", int'({refCmd, cke}), 3);
    o = expOwed;
    step();
    check(int'(owedCount) == expOwed && expOwed <= o, "R6 owed paid down",
          int'(owedCount), expOwed);
    // R7: hold for TRFC-1 cycles
    n = 0;
    while (holdCmd && n < 50) begin n++; step(); end
    check(n == TRFC - 1, "R7 refresh hold length", n, TRFC - 1);

    // random phase: grants and bank-idle reports mixed
    for (int i = 0; i < 3000; i++) begin
      refGrant  = ($urandom % 4) == 0;
      banksIdle = ($urandom % 3) != 0;
      step();
    end

    // R8/R9: self-refresh with some owed refreshes pending
    doReset();
    repeat (2 * INTERVAL) step();
    selfReq = 1'b1; banksIdle = 1'b1; refGrant = 1'b1;
    #1;
    check(refReq, "R4 request on self request", int'(refReq), 1);
    step();
    refGrant = 1'b0;
    #1;
    check(refCmd && !cke, "R8 self entry with cke low", int'({refCmd, cke}), 2);
    o = int'(owedCount);
    step();
    for (int i = 0; i < 3 * INTERVAL; i++) begin
      #1;
      check(!cke, "R8 cke low in self-refresh", int'(cke), 0);
      step();
    end
    check(int'(owedCount) == o, "R8 owed frozen", int'(owedCount), o);
    selfReq = 1'b0;
    step();
    #1;
    check(cke, "R9 cke rises on exit", int'(cke), 1);
    nh = 0; nr = 0;
    for (int i = 0; i < TXSRD + 4; i++) begin
      #1;
      if (holdCmd) nh++;
      if (holdRead) nr++;
      step();
    end
    check(nh == TXSNR, "R9 non-read exit hold", nh, TXSNR);
    check(nr == TXSRD, "R9 read exit hold", nr, TXSRD);
    repeat (INTERVAL + 3) step();

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule